// File: doc/BRIEF.md
# LED Blink Controller with Autostop

This block drives one LED with a programmable blink pattern. A power-of-two prescaler divides the clock into ticks, and each tick advances a period counter that wraps at a programmed length. The LED is lit while the period counter is below a programmed duty value. Software sets up the pattern through a small word-addressed register port. Writing the control word restarts the pattern from the start of a period.

An optional autostop mode counts completed periods. When the count reaches a programmed limit, the block clears its own enable bit, turns the LED off and raises an interrupt flag. A mask bit in the control word hides that flag from the interrupt output. The next write to the control word clears the flag.

Top module: `led_blinker`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `led_out` is 0 and `irq_out` is 0.
- R2: The registers are addressed by byte address with the low two bits zero. 0x0 is the control word of 7 bits: bits 3:0 time-base select, bit 4 run enable, bit 5 autostop enable, bit 6 interrupt mask. 0x4 is the period length (12 bits) and 0x8 the duty count (12 bits). 0xC is the stop count (16 bits). Unused upper bits read 0. A misaligned access writes nothing and reads 0.
- R3: With time-base select n, the period counter advances once every 2^(13-n) clock cycles. A select above 13 behaves as 13, so the counter advances every cycle.
- R4: While enabled, the period counter runs 0 up to length-1 and then wraps. A length of 0 behaves as 1. `led_out` is 1 exactly while the counter is below the duty count.
- R5: A duty count greater than or equal to the period length keeps the LED on for as long as it is enabled. A duty count of 0 keeps it off.
- R6: A write to the control word restarts the prescaler, the period counter and the completed-period count. In the cycle after the write, the counter is 0.
- R7: With autostop enabled, when the number of completed periods reaches the stop count, the run-enable bit clears, the LED turns off and the interrupt flag sets. A stop count of 0 never stops.
- R8: `irq_out` is the interrupt flag gated by the mask bit being 0. Any write to the control word clears the flag.
- R9: While run enable is 0, `led_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (4) | Byte address of the register |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Combinational read data for `reg_addr` |
| led_out | output | 1 | LED drive |
| irq_out | output | 1 | Interrupt request after masking |

## Verification
The hardest state to reach is the exact cycle in which autostop fires. It sits A times period times 2^(13-n) cycles after the control write, and the interrupt and the LED change together at that edge. The bench writes length, duty and stop count first and the control word last, so the cycle of that write is the time origin. It then compares the LED and the interrupt against a cycle-indexed model on every cycle across the boundary. The masked case and the flag clear on a control write are reached by rewriting the control word once the stop has occurred.

// File: rtl/led_blink_pkg.sv
// Package: shared control-word layout and register selectors for the
// LED blinker. Assumes a 4-bit time-base select field.
package led_blink_pkg;

    localparam int CTRL_W = 7;

    typedef struct packed {
        logic       irq_mask;   // bit 6
        logic       auto_en;    // bit 5
        logic       run_en;     // bit 4
        logic [3:0] tb_sel;     // bits 3:0
    } ctrl_t;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_PERIOD = 2'd1;
    localparam logic [1:0] SEL_DUTY   = 2'd2;
    localparam logic [1:0] SEL_STOP   = 2'd3;

endpackage

// File: rtl/led_prescaler.sv
// Module: power-of-two tick generator. It emits one tick every
// 2^(TB_MAX - sel) cycles, clamping sel at TB_MAX. It assumes that
// restart comes in the same cycle as any change to tb_sel.
module led_prescaler #(
    parameter int TB_MAX = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [3:0] tb_sel,
    output logic       tick
);
    localparam int         PRESC_W = TB_MAX;
    localparam logic [3:0] SEL_MAX = 4'(TB_MAX);

    logic [3:0]         sel_c;
    logic [3:0]         shamt;
    logic [PRESC_W:0]   span;
    logic [PRESC_W-1:0] limit;
    logic [PRESC_W-1:0] cnt;

    // Purpose: clamp the select and derive the terminal count.
    always_comb begin
        sel_c = (tb_sel > SEL_MAX) ? SEL_MAX : tb_sel;
        shamt = SEL_MAX - sel_c;
        span  = (PRESC_W+1)'(1) << shamt;
        limit = PRESC_W'(span - (PRESC_W+1)'(1));
    end

    assign tick = run && (cnt == limit);

    // Purpose: divider counter, cleared on restart or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRESC_W'(1);
        end
    end

    a_r3_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);

    a_r6_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

endmodule

// File: rtl/led_period_counter.sv
// Module: period counter and duty compare. It advances on tick, wraps
// after length-1 (a length of 0 acts as 1), and drives the LED while
// the count is below duty. It assumes tick is only high while run is high.
module led_period_counter #(
    parameter int PERIOD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                restart,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period_len,
    input  logic [PERIOD_W-1:0] duty,
    output logic                wrap,
    output logic                led_on
);
    logic [PERIOD_W-1:0] pcnt;
    logic                last;

    // Purpose: detect the final count of the current period.
    always_comb begin
        last = ({1'b0, pcnt} + (PERIOD_W+1)'(1)) >= {1'b0, period_len};
    end

    assign wrap   = tick && last;
    assign led_on = run && (pcnt < duty);

    // Purpose: step the period count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            pcnt <= '0;
        end else if (wrap) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= pcnt + PERIOD_W'(1);
        end
    end

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !restart) |=> $stable(pcnt));

    a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pcnt == '0));

endmodule

// File: rtl/led_autostop.sv
// Module: completed-period counter for autostop. It pulses stop when the
// count of wraps reaches stop_at. A stop_at of zero never matches.
// It assumes that wrap stops once the run enable has been cleared.
module led_autostop #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               auto_en,
    input  logic               wrap,
    input  logic [COUNT_W-1:0] stop_at,
    output logic               stop_pulse
);
    logic [COUNT_W-1:0] done_cnt;
    logic [COUNT_W:0]   next_cnt;

    // Purpose: form the count that this wrap would complete.
    always_comb begin
        next_cnt = {1'b0, done_cnt} + (COUNT_W+1)'(1);
    end

    assign stop_pulse = auto_en && wrap && (next_cnt == {1'b0, stop_at});

    // Purpose: accumulate completed periods while autostop is armed.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            done_cnt <= '0;
        end else if (auto_en && wrap) begin
            done_cnt <= next_cnt[COUNT_W-1:0];
        end
    end

    a_r7_zero_never_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_at == '0) |-> !stop_pulse);

endmodule

// File: rtl/led_blinker.sv
// Module: top of the LED blink controller. It holds the four registers,
// the run enable and the interrupt flag, and wires the prescaler, the
// period counter and the autostop counter. It assumes DATA_W >= COUNT_W,
// DATA_W >= PERIOD_W and DATA_W >= 7.
module led_blinker
    import led_blink_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int PERIOD_W = 12,
    parameter int COUNT_W  = 16,
    parameter int TB_MAX   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              led_out,
    output logic              irq_out
);
    ctrl_t               ctrl;
    logic [PERIOD_W-1:0] period_len;
    logic [PERIOD_W-1:0] duty;
    logic [COUNT_W-1:0]  stop_at;
    logic                irq_flag;

    logic                hit;
    logic [1:0]          sel;
    logic                ctrl_wr;
    logic                tick;
    logic                wrap;
    logic                led_on;
    logic                stop_pulse;

    // Purpose: decode an aligned in-range register address.
    always_comb begin
        hit     = ((reg_addr >> 4) == '0) && (reg_addr[1:0] == 2'b00);
        sel     = reg_addr[3:2];
        ctrl_wr = reg_we && hit && (sel == SEL_CTRL);
    end

    // Purpose: control word; autostop clears the run enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end else if (stop_pulse) begin
            ctrl.run_en <= 1'b0;
        end
    end

    // Purpose: period, duty and stop-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_len <= '0;
            duty       <= '0;
            stop_at    <= '0;
        end else if (reg_we && hit) begin
            case (sel)
                SEL_PERIOD: period_len <= reg_wdata[PERIOD_W-1:0];
                SEL_DUTY:   duty       <= reg_wdata[PERIOD_W-1:0];
                SEL_STOP:   stop_at    <= reg_wdata[COUNT_W-1:0];
                default:    ;
            endcase
        end
    end

    // Purpose: interrupt flag, set by autostop and cleared by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr) begin
            irq_flag <= 1'b0;
        end else if (stop_pulse) begin
            irq_flag <= 1'b1;
        end
    end

    // Purpose: combinational register read-back.
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (sel)
                SEL_CTRL:   reg_rdata = DATA_W'(ctrl);
                SEL_PERIOD: reg_rdata = DATA_W'(period_len);
                SEL_DUTY:   reg_rdata = DATA_W'(duty);
                default:    reg_rdata = DATA_W'(stop_at);
            endcase
        end
    end

    led_prescaler #(.TB_MAX(TB_MAX)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run_en),
        .restart (ctrl_wr),
        .tb_sel  (ctrl.tb_sel),
        .tick    (tick)
    );

    led_period_counter #(.PERIOD_W(PERIOD_W)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl.run_en),
        .restart    (ctrl_wr),
        .tick       (tick),
        .period_len (period_len),
        .duty       (duty),
        .wrap       (wrap),
        .led_on     (led_on)
    );

    led_autostop #(.COUNT_W(COUNT_W)) u_stop (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (ctrl_wr),
        .auto_en    (ctrl.auto_en),
        .wrap       (wrap),
        .stop_at    (stop_at),
        .stop_pulse (stop_pulse)
    );

    assign led_out = led_on;
    assign irq_out = irq_flag && !ctrl.irq_mask;

    a_r7_stop_effects: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && !ctrl_wr) |=> (!ctrl.run_en && irq_flag && !led_out));

    a_r8_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !irq_flag);

    a_r8_mask_hides_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.irq_mask |-> !irq_out);

    a_r9_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run_en |-> !led_out);

endmodule

// File: tb/led_blinker_test.sv
// Directed bench for led_blinker: one task per scenario, each checking
// its own results against a cycle-indexed model of the requirements.
module led_blinker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        led_out;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    led_blinker uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .led_out   (led_out),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    function automatic logic [15:0] cval(input bit mask, input bit auto_en,
                                         input bit en, input int tb);
        return {9'h0, mask, auto_en, en, 4'(tb)};
    endfunction

    // Compare LED and IRQ each cycle from the control write onward.
    task automatic run_check(input int s, input int p, input int d, input int a,
                             input bit auto_en, input bit mask, input int n,
                             input string tag);
        int pe;
        pe = (p == 0) ? 1 : p;
        for (int j = 0; j < n; j++) begin
            bit stopped;
            bit exp_led;
            stopped = auto_en && (a != 0) && (j >= a * pe * (1 << s));
            exp_led = !stopped && (((j >> s) % pe) < d);
            check($sformatf("%s led cyc%0d", tag, j), {31'h0, led_out}, {31'h0, exp_led});
            check($sformatf("%s irq cyc%0d", tag, j), {31'h0, irq_out},
                  {31'h0, (stopped && !mask)});
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1 led after reset", {31'h0, led_out}, 32'h0);
        check("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        rd_check(4'h0, 16'h0, "R1 ctrl reset");
        rd_check(4'h4, 16'h0, "R1 period reset");
        rd_check(4'h8, 16'h0, "R1 duty reset");
        rd_check(4'hC, 16'h0, "R1 stop reset");
    endtask

    task automatic t_regs;
        wr(4'h0, 16'hFF8F);
        rd_check(4'h0, 16'h000F, "R2 ctrl width");
        wr(4'h4, 16'hFFFF);
        rd_check(4'h4, 16'h0FFF, "R2 period width");
        wr(4'h8, 16'hF123);
        rd_check(4'h8, 16'h0123, "R2 duty width");
        wr(4'hC, 16'hBEEF);
        rd_check(4'hC, 16'hBEEF, "R2 stop width");
        wr(4'h5, 16'h0055);
        rd_check(4'h4, 16'h0FFF, "R2 misaligned write ignored");
        rd_check(4'h5, 16'h0000, "R2 misaligned read zero");
    endtask

    task automatic t_basic;
        wr(4'h4, 16'd5); wr(4'h8, 16'd2); wr(4'hC, 16'd0);
        wr(4'h0, cval(0, 0, 1, 13));
        run_check(0, 5, 2, 0, 0, 0, 32, "R4 blink p5 d2");
        wr(4'h0, cval(0, 0, 1, 13));
        run_check(0, 5, 2, 0, 0, 0, 12, "R6 restart phase");
    endtask

    task automatic t_timebase;
        wr(4'h4, 16'd3); wr(4'h8, 16'd1);
        wr(4'h0, cval(0, 0, 1, 11));
        run_check(2, 3, 1, 0, 0, 0, 48, "R3 tb11");
        wr(4'h4, 16'd4); wr(4'h8, 16'd3);
        wr(4'h0, cval(0, 0, 1, 15));
        run_check(0, 4, 3, 0, 0, 0, 16, "R3 tb15 clamps");
    endtask

    task automatic t_duty_edges;
        wr(4'h4, 16'd4); wr(4'h8, 16'd4);
        wr(4'h0, cval(0, 0, 1, 13));
        run_check(0, 4, 4, 0, 0, 0, 12, "R5 duty eq period");
        wr(4'h8, 16'd9);
        wr(4'h0, cval(0, 0, 1, 13));
        run_check(0, 4, 9, 0, 0, 0, 12, "R5 duty above period");
        wr(4'h8, 16'd0);
        wr(4'h0, cval(0, 0, 1, 13));
        run_check(0, 4, 0, 0, 0, 0, 12, "R5 duty zero");
        wr(4'h4, 16'd0); wr(4'h8, 16'd1);
        wr(4'h0, cval(0, 0, 1, 13));
        run_check(0, 0, 1, 0, 0, 0, 8, "R4 period zero");
    endtask

    task automatic t_autostop;
        wr(4'h4, 16'd3); wr(4'h8, 16'd1); wr(4'hC, 16'd4);
        wr(4'h0, cval(0, 1, 1, 13));
        run_check(0, 3, 1, 4, 1, 0, 20, "R7 autostop a4");
        rd_check(4'h0, cval(0, 1, 0, 13), "R7 enable cleared");
        wr(4'h0, cval(1, 1, 1, 12));
        run_check(1, 3, 1, 4, 1, 1, 30, "R8 masked autostop");
        wr(4'h0, cval(0, 0, 0, 13));
        check("R8 control write clears flag", {31'h0, irq_out}, 32'h0);
        wr(4'hC, 16'd0);
        wr(4'h0, cval(0, 1, 1, 13));
        run_check(0, 3, 1, 0, 1, 0, 30, "R7 stop count zero");
    endtask

    task automatic t_disabled;
        wr(4'h4, 16'd4); wr(4'h8, 16'd4);
        wr(4'h0, cval(0, 0, 0, 13));
        for (int j = 0; j < 16; j++) begin
            check($sformatf("R9 idle led cyc%0d", j), {31'h0, led_out}, 32'h0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_timebase();
        t_duty_edges();
        t_autostop();
        t_disabled();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule